// File: doc/BRIEF.md
# Timed Packet-to-Frame Assembler

This block gathers byte-wide packets that all belong to one forwarding class and packs them back-to-back into fixed-size container frames. Arriving bytes go into a packet store; a packet counts toward the fill level only once its last byte has been taken. A frame is released when the committed fill level reaches a size threshold. It is also released when a starvation timer runs out, so a lone packet does not wait forever for more traffic.

Each packet, or each piece of a packet, is preceded by a two-byte delineation header so that a receiver can split the frame back into packets. A packet that does not fit in the space left in a frame is cut. The cut piece closes the frame and the remainder opens the next one. When no more committed data is available, the rest of the frame is filled with zero bytes.

The frame leaves as one unbroken burst of exactly `FRAME_BYTES` bytes, with a marker on the final byte. The input is throttled only when a frame is being read out and the store is too full to take a whole maximum-size packet, or when the packet-length queue is full.

Top module: `frame_packer`

## Requirements
- R1: While reset is high and after it is released with no input, `out_valid` is 0 and `in_ready` is 1.
- R2: Every frame is exactly `FRAME_BYTES` consecutive cycles of `out_valid` with no gap. `out_last` is 1 on the final byte only, and at least one idle cycle follows each frame.
- R3: Each piece starts with a two-byte header, high byte first. Bit 15 is set when the packet continues in the next frame, bit 14 is set when the piece continues a packet from the previous frame, and bits 13:0 give the piece length in bytes. The piece's payload bytes follow at once.
- R4: When the committed payload held in the store reaches `THRESH_BYTES` while no frame is in progress, the frame's first byte appears within 5 cycles of the packet that crossed the threshold.
- R5: The timer starts only when a packet completes into a store with no committed data. If the threshold is never reached, the frame starts `TIMEOUT_CYC`+1 cycles after that packet's last byte is taken, and never earlier.
- R6: A piece carries min(remaining packet bytes, space left in the frame − 2) bytes. A packet that is cut continues at byte 0 of the next frame, in a piece with bit 14 set.
- R7: When no committed data is left, or fewer than 3 bytes of space remain, the rest of the frame is zero bytes. A header with length zero therefore marks the start of padding.
- R8: After a frame ends, the timer restarts at once if committed data remains, so the next frame starts `TIMEOUT_CYC`+1 cycles after the last byte of the previous one. If the store is empty, no frame is produced until a new packet arrives.
- R9: `in_ready` is 0 when a frame is in progress and fewer than `MAX_PKT` bytes are free in the store, or when the length queue is full. Otherwise it is 1, and under sustained input the store never overflows.
- R10: The payload bytes of every packet leave the block unchanged and in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input packet byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte (header, payload or padding) |
| out_last | output | 1 | Final byte of a frame |

## Verification
The assertions take for granted that packets are well formed. Each packet opens with `in_sop`, closes with `in_eop`, and is at most `MAX_PKT` bytes long. The parameters must also leave room in the store: `BUF_DEPTH` of at least `THRESH_BYTES` plus twice `MAX_PKT`. Under those assumptions the store and the length queue can never overflow or underflow. The stimulus only ever sends complete packets of 32 bytes or fewer, with sizes chosen to hit exact frame boundaries. It holds each byte until `in_ready` is seen, including during a long burst that forces the store near full.

// File: rtl/fp_pkg.sv
package fp_pkg;

  localparam int LEN_W = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HHI,
    ST_HLO,
    ST_DATA,
    ST_PAD
  } emit_st_t;

  typedef struct packed {
    logic             cont_next;
    logic             cont_prev;
    logic [LEN_W-1:0] len;
  } piece_hdr_t;

endpackage

// File: rtl/fp_byte_store.sv
module fp_byte_store #(
  parameter int DEPTH = 4096
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  input  logic                     rd_en,
  output logic [7:0]               rd_q,
  output logic [$clog2(DEPTH):0]   used
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_nxt;

  assign rd_nxt = rd_en ? ((rd_ptr == TOP) ? '0 : rd_ptr + 1'b1) : rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    rd_q <= mem[rd_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == TOP) ? '0 : wr_ptr + 1'b1;
      rd_ptr <= rd_nxt;
      used   <= used + (wr_en ? 1'b1 : 1'b0) - (rd_en ? 1'b1 : 1'b0);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (used != (AW+1)'(DEPTH)) || rd_en); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> used != '0); // R10

endmodule

// File: rtl/fp_len_queue.sv
module fp_len_queue import fp_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [LEN_W-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [QW-1:0] TOP = QW'(DEPTH - 1);

  logic [LEN_W-1:0] q [DEPTH];
  logic [QW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  assign head  = q[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) q[wp] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == TOP) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == TOP) ? '0 : rp + 1'b1;
      cnt <= cnt + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  AST_LQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full || pop); // R9
  AST_LQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R10

endmodule

// File: rtl/fp_release_timer.sv
module fp_release_timer #(
  parameter int TIMEOUT_CYC = 156250
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic restart,
  input  logic restart_keep,
  input  logic hold,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic          run;
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (restart) begin
      run <= restart_keep;
      cnt <= '0;
    end else if (arm) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run && !hold && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT); // R5

endmodule

// File: rtl/fp_frame_emitter.sv
module fp_frame_emitter import fp_pkg::*; #(
  parameter int FRAME_BYTES = 9000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             lq_empty,
  input  logic [LEN_W-1:0] lq_head,
  output logic             lq_pop,
  output logic             rd_en,
  input  logic [7:0]       rd_q,
  output logic             busy,
  output logic             frame_end,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last
);
  localparam int PW = $clog2(FRAME_BYTES);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BYTES - 1);

  emit_st_t         st;
  logic [PW-1:0]    pos;
  logic [LEN_W-1:0] pkt_rem, piece_rem;
  piece_hdr_t       hdr, dec_hdr;
  logic [15:0]      hdr_bits;
  logic [7:0]       emit_byte;
  int               dspace, room, crem, plen;
  logic             have, go, dec_now;

  assign hdr_bits = hdr;

  // Piece decision: made at frame start and on the last byte of a piece
  always_comb begin
    dspace = (st == ST_IDLE) ? FRAME_BYTES : FRAME_BYTES - int'(pos) - 1;
    room   = dspace - 2;
    have   = (pkt_rem != '0) || !lq_empty;
    crem   = (pkt_rem != '0) ? int'(pkt_rem) : int'(lq_head);
    plen   = (crem > room) ? room : crem;
    go     = have && (dspace >= 3);
    dec_hdr.cont_next = (crem > room);
    dec_hdr.cont_prev = (pkt_rem != '0);
    dec_hdr.len       = LEN_W'(plen);
    dec_now = (st == ST_IDLE && start) ||
              (st == ST_DATA && piece_rem == LEN_W'(1) && pos != LAST_POS);
  end

  assign lq_pop    = dec_now && go && (pkt_rem == '0);
  assign rd_en     = (st == ST_DATA);
  assign busy      = (st != ST_IDLE);
  assign frame_end = busy && (pos == LAST_POS);

  always_comb begin
    case (st)
      ST_HHI:  emit_byte = hdr_bits[15:8];
      ST_HLO:  emit_byte = hdr_bits[7:0];
      ST_DATA: emit_byte = rd_q;
      default: emit_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pos       <= '0;
      pkt_rem   <= '0;
      piece_rem <= '0;
      hdr       <= '0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else begin
      out_valid <= busy;
      out_last  <= frame_end;
      out_data  <= emit_byte;
      if (busy) pos <= frame_end ? '0 : pos + 1'b1;
      if (dec_now) begin
        if (go) begin
          hdr       <= dec_hdr;
          piece_rem <= LEN_W'(plen);
          pkt_rem   <= LEN_W'(crem - plen);
          st        <= ST_HHI;
        end else begin
          st <= ST_PAD;
        end
      end else begin
        case (st)
          ST_HHI:  st <= ST_HLO;
          ST_HLO:  st <= ST_DATA;
          ST_DATA: begin
            piece_rem <= piece_rem - 1'b1;
            if (frame_end) st <= ST_IDLE;
          end
          ST_PAD:  if (frame_end) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_FRAME_CONT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |=> out_valid); // R2
  AST_FRAME_GAP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |=> !out_valid); // R2
  AST_PIECE_FITS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HHI) |-> (int'(pos) + 2 + int'(hdr.len) <= FRAME_BYTES)); // R6

endmodule

// File: rtl/frame_packer.sv
module frame_packer import fp_pkg::*; #(
  parameter int FRAME_BYTES  = 9000,
  parameter int THRESH_BYTES = 1024,
  parameter int MAX_PKT      = 1520,
  parameter int BUF_DEPTH    = 4096,
  parameter int LEN_DEPTH    = 16,
  parameter int TIMEOUT_CYC  = 156250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int AW  = $clog2(BUF_DEPTH);
  localparam int LVW = AW + 1;

  logic [LVW-1:0]   used, free_b, level, level_nxt;
  logic [7:0]       rd_q;
  logic             rd_en, wr_en, commit;
  logic             lq_full, lq_empty, lq_pop;
  logic [LEN_W-1:0] lq_head, wr_len, pkt_len;
  logic             busy, frame_end, expired, start;

  assign free_b   = LVW'(BUF_DEPTH) - used;
  assign in_ready = !((busy && (free_b < LVW'(MAX_PKT))) || lq_full);
  assign wr_en    = in_valid && in_ready;
  assign commit   = wr_en && in_eop;
  assign pkt_len  = in_sop ? LEN_W'(1) : wr_len + 1'b1;

  assign level_nxt = level + (commit ? LVW'(pkt_len) : '0) - (rd_en ? LVW'(1) : '0);
  assign start     = !busy && (level != '0) &&
                     ((level >= LVW'(THRESH_BYTES)) || expired);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_len <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_len <= pkt_len;
      level <= level_nxt;
    end
  end

  fp_byte_store #(.DEPTH(BUF_DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(in_data),
    .rd_en(rd_en), .rd_q(rd_q), .used(used)
  );

  fp_len_queue #(.DEPTH(LEN_DEPTH)) u_lenq (
    .clk(clk), .rst(rst), .push(commit), .push_len(pkt_len),
    .pop(lq_pop), .head(lq_head), .empty(lq_empty), .full(lq_full)
  );

  fp_release_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst),
    .arm(commit && (level == '0)),
    .restart(frame_end), .restart_keep(level_nxt != '0),
    .hold(busy), .expired(expired)
  );

  fp_frame_emitter #(.FRAME_BYTES(FRAME_BYTES)) u_emit (
    .clk(clk), .rst(rst), .start(start),
    .lq_empty(lq_empty), .lq_head(lq_head), .lq_pop(lq_pop),
    .rd_en(rd_en), .rd_q(rd_q), .busy(busy), .frame_end(frame_end),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  AST_RELEASE_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(level) != '0); // R4
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= used); // R10

endmodule

// File: tb/tb_frame_packer.sv
module tb_frame_packer;
  localparam int F    = 64;
  localparam int TH   = 40;
  localparam int MAXP = 32;
  localparam int DEP  = 128;
  localparam int LQD  = 8;
  localparam int TO   = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid, out_last;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  frame_packer #(.FRAME_BYTES(F), .THRESH_BYTES(TH), .MAX_PKT(MAXP),
                 .BUF_DEPTH(DEP), .LEN_DEPTH(LQD), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  int tests = 0, fails = 0, cyc = 0;
  int frames = 0, fidx = 0, fstart_cyc = 0, fend_cyc = 0, t_eop = 0;
  int cur_rem = 0;
  bit saw_bp = 0;
  bit done = 0;
  logic [7:0] fbuf  [F];
  logic [7:0] lastf [F];
  int exp_len_q [$];
  logic [7:0] exp_byte_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  // Splits a captured frame into pieces and compares against sent packets (R3, R6, R7, R10)
  task automatic parse_frame();
    int  pos = 0;
    bit  ok = 1;
    while (pos + 3 <= F) begin
      int hv  = {fbuf[pos], fbuf[pos+1]};
      int len = hv & 16'h3fff;
      bit cn  = hv[15];
      bit cp  = hv[14];
      if (len == 0) break;
      if (cp != (cur_rem > 0)) ok = 0;
      if (!cp) begin
        if (exp_len_q.size() == 0) begin ok = 0; break; end
        cur_rem = exp_len_q.pop_front();
      end
      if (len > cur_rem || pos + 2 + len > F) begin ok = 0; break; end
      for (int i = 0; i < len; i++) begin
        if (exp_byte_q.size() == 0) ok = 0;
        else if (fbuf[pos+2+i] != exp_byte_q.pop_front()) ok = 0;
      end
      cur_rem -= len;
      if (cn != (cur_rem > 0)) ok = 0;
      pos += 2 + len;
    end
    for (int i = pos; i < F; i++) if (fbuf[i] != 8'h00) ok = 0;
    check(ok, "R10", "frame content matches sent packets", ok, 1);
  endtask

  always @(negedge clk) begin
    if (!rst && in_valid && !in_ready) saw_bp = 1;
    if (!rst && out_valid) begin
      if (fidx == 0) fstart_cyc = cyc;
      if (fidx < F) fbuf[fidx] = out_data;
      fidx++;
      if (out_last) begin
        check_eq("R2", "frame length at out_last", fidx, F);
        lastf    = fbuf;
        fend_cyc = cyc;
        fidx     = 0;
        parse_frame();
        frames++;
      end else if (fidx > F) begin
        check_eq("R2", "frame overran without out_last", fidx, F);
        fidx = 0;
      end
    end
  end

  task automatic send_pkt(input int len, input int seed);
    exp_len_q.push_back(len);
    for (int i = 0; i < len; i++) exp_byte_q.push_back(8'((seed + i * 7) & 255));
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'((seed + i * 7) & 255);
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    t_eop = cyc;
  endtask

  task automatic wait_frames(input int target);
    int n = 0;
    while (frames < target && n < 5000) begin @(negedge clk); n++; end
    check(frames >= target, "R2", "expected frame did not appear", frames, target);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", "out_valid in reset", int'(out_valid), 0);
    check_eq("R1", "in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check_eq("R1", "out_valid after reset", int'(out_valid), 0);
    check_eq("R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_timeout();
    int f0 = frames;
    int eop_at, lat;
    bit zeros = 1;
    send_pkt(10, 3);
    eop_at = t_eop;
    wait_frames(f0 + 1);
    lat = fstart_cyc - eop_at;
    check(lat >= TO && lat <= TO + 3, "R5", "timeout latency", lat, TO + 1);
    check_eq("R3", "header high byte", int'(lastf[0]), 0);
    check_eq("R3", "header low byte", int'(lastf[1]), 10);
    check_eq("R3", "first payload byte", int'(lastf[2]), 3);
    for (int i = 12; i < F; i++) if (lastf[i] != 8'h00) zeros = 0;
    check(zeros, "R7", "padding bytes zero", zeros, 1);
  endtask

  task automatic t_thresh();
    int f0 = frames;
    int eop_at, lat, f1;
    send_pkt(20, 40);
    send_pkt(25, 90);
    eop_at = t_eop;
    wait_frames(f0 + 1);
    lat = fstart_cyc - eop_at;
    check(lat >= 0 && lat <= 5, "R4", "threshold release latency", lat, 2);
    check_eq("R3", "second header high", int'(lastf[22]), 0);
    check_eq("R3", "second header low", int'(lastf[23]), 25);
    check_eq("R7", "zero header after data", int'({lastf[49], lastf[50]}), 0);
    f1 = frames;
    repeat (2 * TO + 20) @(negedge clk);
    check_eq("R8", "no frame with empty store", frames, f1);
  endtask

  task automatic t_frag();
    int f0 = frames;
    int end1, lat;
    send_pkt(30, 7);
    send_pkt(32, 150);
    wait_frames(f0 + 1);
    end1 = fend_cyc;
    check_eq("R6", "cut piece header high", int'(lastf[32]), 8'h80);
    check_eq("R6", "cut piece header low", int'(lastf[33]), 30);
    wait_frames(f0 + 2);
    check_eq("R6", "remainder header high", int'(lastf[0]), 8'h40);
    check_eq("R6", "remainder header low", int'(lastf[1]), 2);
    lat = fstart_cyc - end1;
    check(lat >= TO && lat <= TO + 3, "R8", "restart after release", lat, TO + 1);
  endtask

  task automatic t_tail();
    int f0 = frames;
    send_pkt(30, 11);
    send_pkt(28, 77);
    send_pkt(5, 200);
    wait_frames(f0 + 1);
    check_eq("R3", "second piece length", int'({lastf[32], lastf[33]}), 28);
    check_eq("R7", "short tail padded", int'({lastf[62], lastf[63]}), 0);
    wait_frames(f0 + 2);
    check_eq("R7", "next packet opens next frame", int'({lastf[0], lastf[1]}), 5);
  endtask

  task automatic t_backpressure();
    int n = 0;
    saw_bp = 0;
    for (int p = 0; p < 40; p++) send_pkt(32, p * 13);
    check(saw_bp, "R9", "in_ready dropped under sustained load", saw_bp, 1);
    while ((exp_len_q.size() != 0 || cur_rem != 0) && n < 20000) begin
      @(negedge clk); n++;
    end
    check_eq("R10", "packets left undelivered", exp_len_q.size() + cur_rem, 0);
    repeat (4) @(negedge clk);
    check_eq("R9", "in_ready back high when idle", int'(in_ready), 1);
  endtask

  initial begin
    t_reset();
    t_timeout();
    t_thresh();
    t_frag();
    t_tail();
    t_backpressure();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule